// File: doc/BRIEF.md
# Strobe Delay-Locked Loop Code Controller

This block holds the digital control state of a delay-locked loop that phase-shifts a memory read strobe. An external phase detector compares the end of a delay line of at most 16 stages with the reference clock. The detector reports a direction and an enable strobe. On each enabled update the block moves a 6-bit delay code one step up or one step down. Over time this brings the delay line into phase with the reference. The delay line and the detector are not part of this block.

The raw delay code goes to the fabric and to the strobe logic. A second, registered stage applies a fabric-supplied 6-bit offset to that code, by addition or by subtraction, and clamps the result. The offset code is meant only for the strobe delay logic. A zero-degree shift request bypasses the loop and the strobe delay. The block then raises a bypass flag, freezes the code and drives the offset code to zero. A lock flag reports when the loop has settled into dithering around the phase point.

Top module: `dll_delay_ctrl`

## Requirements
- R1: Under synchronous reset the delay code is 32, the offset code is 0, and bypass and locked are both 0.
- R2: The delay code changes only on a clock edge where `cmp_en` is 1 and `zero_shift` is 0; otherwise it holds.
- R3: On an enabled update, `cmp_up` = 1 raises the delay code by exactly one and `cmp_up` = 0 lowers it by exactly one.
- R4: The delay code saturates at 63 when stepping up and at 0 when stepping down, and never wraps.
- R5: With `ofs_sub` = 0 the offset code is the delay code plus `ofs_val`, clamped to 63.
- R6: With `ofs_sub` = 1 the offset code is the delay code minus `ofs_val`, clamped to 0.
- R7: The offset code is registered from the registered delay code, so it follows a delay code change one clock later.
- R8: `zero_shift` appears on `bypass` one clock later. While `zero_shift` is held, the delay code is frozen and the offset code is 0.
- R9: `locked` rises after 8 consecutive enabled updates that each reverse the direction of the update before them, which means 9 alternating updates counted from the first.
- R10: A locked loop drops `locked` after 3 consecutive enabled updates in the same direction; fewer than 3 keep it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | 1 | Phase detector update strobe |
| cmp_up | input | 1 | Phase detector direction, 1 = more delay |
| ofs_val | input | 6 | Offset magnitude from fabric |
| ofs_sub | input | 1 | 1 = subtract offset, 0 = add |
| zero_shift | input | 1 | Zero-degree shift request (bypass) |
| dly_code | output | 6 | Raw delay code |
| ofs_code | output | 6 | Offset-adjusted delay code for strobe logic |
| bypass | output | 1 | Registered bypass indication |
| locked | output | 1 | Loop lock flag |

## Verification
A wrong counter state shows on `dly_code` at the edge after the update. An offset-stage fault appears on `ofs_code` one edge later than that. A missing saturation wraps the code to 0 or 63 on the first update past a bound. A wrong direction or alternation history in the lock tracker stays hidden until the ninth alternating update or the third repeated update, so the lock tests drive exactly those counts and check one update short of each.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;
  typedef enum logic {DIR_DN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/dll_code_counter.sv
module dll_code_counter #(
  parameter int W        = 6,
  parameter int RST_CODE = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         step_up,
  output logic [W-1:0] code
);
  localparam logic [W-1:0] MAXC  = {W{1'b1}};
  localparam logic [W-1:0] INITC = W'(RST_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= INITC;
    end else if (step_en) begin
      if (step_up == dll_ctrl_pkg::DIR_UP) begin
        if (code != MAXC) code <= code + 1'b1;
      end else begin
        if (code != '0) code <= code - 1'b1;
      end
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(code));
  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (code == $past(code)) || (code == $past(code) + 1'b1) ||
                (code == $past(code) - 1'b1));
  // R4
  no_wrap_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_up && code == MAXC) |=> code == MAXC);
  // R4
  no_wrap_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !step_up && code == '0) |=> code == '0);
endmodule

// File: rtl/dll_offset_unit.sv
module dll_offset_unit #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] code,
  input  logic [W-1:0] ofs_val,
  input  logic         ofs_sub,
  input  logic         force_zero,
  output logic [W-1:0] ofs_code
);
  localparam logic [W-1:0] MAXC = {W{1'b1}};

  logic [W:0]   sum;
  logic [W-1:0] res;

  always_comb begin
    sum = {1'b0, code} + {1'b0, ofs_val};
    if (ofs_sub) begin
      res = (ofs_val > code) ? '0 : (code - ofs_val);
    end else begin
      res = sum[W] ? MAXC : sum[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             ofs_code <= '0;
    else if (force_zero) ofs_code <= '0;
    else                 ofs_code <= res;
  end

  // R8
  zero_chk: assert property (@(posedge clk) disable iff (rst)
    force_zero |=> ofs_code == '0);
  // R5
  add_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!force_zero && !ofs_sub) |=> ofs_code >= $past(code));
  // R6
  sub_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!force_zero && ofs_sub) |=> ofs_code <= $past(code));
endmodule

// File: rtl/dll_lock_detect.sv
module dll_lock_detect #(
  parameter int ALT_N = 8,
  parameter int RUN_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic upd_up,
  output logic locked
);
  localparam int AW = $clog2(ALT_N + 1);
  localparam int RW = $clog2(RUN_N + 1);
  localparam logic [AW-1:0] ALT_LAST = AW'(ALT_N - 1);
  localparam logic [AW-1:0] ALT_TOP  = AW'(ALT_N);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_N - 1);
  localparam logic [RW-1:0] RUN_TOP  = RW'(RUN_N);

  logic          have_prev;
  logic          last_up;
  logic [AW-1:0] alt_cnt;
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      last_up   <= 1'b0;
      alt_cnt   <= '0;
      run_cnt   <= '0;
      locked    <= 1'b0;
    end else if (upd) begin
      have_prev <= 1'b1;
      last_up   <= upd_up;
      if (!have_prev) begin
        alt_cnt <= '0;
        run_cnt <= RW'(1);
      end else if (upd_up != last_up) begin
        run_cnt <= RW'(1);
        if (alt_cnt != ALT_TOP) alt_cnt <= alt_cnt + 1'b1;
        if (alt_cnt >= ALT_LAST) locked <= 1'b1;
      end else begin
        alt_cnt <= '0;
        if (run_cnt != RUN_TOP) run_cnt <= run_cnt + 1'b1;
        if (run_cnt >= RUN_LAST) locked <= 1'b0;
      end
    end
  end

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(locked));
  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(upd) && ($past(upd_up) != $past(last_up)));
  // R10
  lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(upd) && ($past(upd_up) == $past(last_up)));
endmodule

// File: rtl/dll_delay_ctrl.sv
module dll_delay_ctrl #(
  parameter int W        = 6,
  parameter int RST_CODE = 32,
  parameter int ALT_N    = 8,
  parameter int RUN_N    = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_en,
  input  logic         cmp_up,
  input  logic [W-1:0] ofs_val,
  input  logic         ofs_sub,
  input  logic         zero_shift,
  output logic [W-1:0] dly_code,
  output logic [W-1:0] ofs_code,
  output logic         bypass,
  output logic         locked
);
  logic upd;
  assign upd = cmp_en & ~zero_shift;

  dll_code_counter #(.W(W), .RST_CODE(RST_CODE)) u_cnt (
    .clk(clk), .rst(rst), .step_en(upd), .step_up(cmp_up), .code(dly_code)
  );

  dll_offset_unit #(.W(W)) u_ofs (
    .clk(clk), .rst(rst), .code(dly_code), .ofs_val(ofs_val),
    .ofs_sub(ofs_sub), .force_zero(zero_shift), .ofs_code(ofs_code)
  );

  dll_lock_detect #(.ALT_N(ALT_N), .RUN_N(RUN_N)) u_lock (
    .clk(clk), .rst(rst), .upd(upd), .upd_up(cmp_up), .locked(locked)
  );

  always_ff @(posedge clk) begin
    if (rst) bypass <= 1'b0;
    else     bypass <= zero_shift;
  end

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    zero_shift |=> bypass && $stable(dly_code));
  // R7
  ofs_lag_chk: assert property (@(posedge clk) disable iff (rst)
    (!zero_shift && !ofs_sub && ofs_val == '0) |=> ofs_code == $past(dly_code));
endmodule

// File: tb/tb_dll_delay_ctrl.sv
`timescale 1ns/1ps
module tb_dll_delay_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_en = 1'b0, cmp_up = 1'b0, ofs_sub = 1'b0, zero_shift = 1'b0;
  logic [5:0] ofs_val = '0;
  logic [5:0] dly_code, ofs_code;
  logic       bypass, locked;
  int checks = 0, fails = 0;
  int exp_code = 32;

  always #2.5 clk = ~clk;

  dll_delay_ctrl dut (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .cmp_up(cmp_up), .ofs_val(ofs_val),
    .ofs_sub(ofs_sub), .zero_shift(zero_shift), .dly_code(dly_code),
    .ofs_code(ofs_code), .bypass(bypass), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic step(input logic up, input int n);
    for (int i = 0; i < n; i++) begin
      cmp_en = 1'b1; cmp_up = up;
      @(negedge clk);
      cmp_en = 1'b0;
      if (up && exp_code < 63) exp_code++;
      if (!up && exp_code > 0) exp_code--;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cmp_en = 1'b0; zero_shift = 1'b0; ofs_val = '0; ofs_sub = 1'b0;
    idle(2);
    rst = 1'b0; exp_code = 32;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 dly", int'(dly_code), 32);
    chk("R1 ofs", int'(ofs_code), 0);
    chk("R1 bypass", int'(bypass), 0);
    chk("R1 locked", int'(locked), 0);
  endtask

  task automatic t_gate_and_dir();
    do_reset();
    cmp_up = 1'b1; idle(3);
    chk("R2 no enable", int'(dly_code), 32);
    step(1'b1, 5);
    chk("R3 up", int'(dly_code), 37);
    step(1'b0, 3);
    chk("R3 down", int'(dly_code), 34);
  endtask

  task automatic t_saturate();
    do_reset();
    step(1'b1, 40);
    chk("R4 high", int'(dly_code), 63);
    step(1'b0, 70);
    chk("R4 low", int'(dly_code), 0);
  endtask

  task automatic t_offset();
    do_reset();
    step(1'b1, 8);
    ofs_val = 6'd10; ofs_sub = 1'b0; idle(1);
    chk("R5 add", int'(ofs_code), 50);
    ofs_val = 6'd40; idle(1);
    chk("R5 clamp", int'(ofs_code), 63);
    ofs_sub = 1'b1; ofs_val = 6'd15; idle(1);
    chk("R6 sub", int'(ofs_code), 25);
    ofs_val = 6'd60; idle(1);
    chk("R6 clamp", int'(ofs_code), 0);
  endtask

  task automatic t_latency();
    do_reset();
    ofs_val = '0; ofs_sub = 1'b0; idle(2);
    step(1'b1, 1);
    chk("R7 code moved", int'(dly_code), 33);
    chk("R7 ofs lags", int'(ofs_code), 32);
    idle(1);
    chk("R7 ofs follows", int'(ofs_code), 33);
  endtask

  task automatic t_bypass();
    do_reset();
    ofs_val = 6'd5; idle(1);
    zero_shift = 1'b1;
    step(1'b1, 4);
    chk("R8 bypass", int'(bypass), 1);
    chk("R8 frozen", int'(dly_code), 32);
    chk("R8 ofs zero", int'(ofs_code), 0);
    zero_shift = 1'b0; idle(2);
    chk("R8 release", int'(bypass), 0);
    chk("R8 ofs back", int'(ofs_code), 37);
  endtask

  task automatic t_lock();
    do_reset();
    for (int i = 0; i < 8; i++) step(i % 2 == 0, 1);
    chk("R9 not yet", int'(locked), 0);
    step(1'b1, 1);
    chk("R9 locked", int'(locked), 1);
    step(1'b1, 1);
    chk("R10 two same keeps", int'(locked), 1);
    step(1'b1, 1);
    chk("R10 three same clears", int'(locked), 0);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_gate_and_dir();
    t_saturate();
    t_offset();
    t_latency();
    t_bypass();
    t_lock();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule